// File: doc/BRIEF.md
# External Bus Pin-Function Select Register

This block holds the 16-bit configuration word that decides, for each group of external bus pins, which of two functions the pin group carries. Six fields in the low byte steer the pin multiplexers: column-strobe pins versus interrupt-acknowledge strobes (two groups), chip select versus level-7 acknowledge, autovector input versus level-5 acknowledge, address-mux strobe versus output enable, and the top four address bits versus the four byte write enables. The remaining writable high-byte bits are stored and handed out unchanged to the logic that owns them.

The four pins shared between high address bits and byte write enables must not drive anything until software has chosen their function. A sticky flag records the first write that touches the low byte. That flag reads back in the register and is also the output enable for that pin group. A write that touches only the high byte leaves the pins three-stated. The register can be read or written at any time. The select outputs follow the stored bits directly, with no extra pipeline stage.

Top module: `pin_select_reg`

## Requirements
- R1: After a cycle with `rst_n` low, `rdata` is 0, every `sel_*` output is 0, `hi_opts` is 0 and `pin_oe` is 0.
- R2: On a rising edge with `wr_en` high, each byte lane whose `byte_en` bit is set (bit 0 = bits 7:0, bit 1 = bits 15:8) loads the writable bits of `wdata`. The writable bits are mask 16'h77D7, that is bits 0,1,2,4,6,7,8,9,10,12,13,14. A lane whose enable is clear keeps its value.
- R3: Bits 3, 11 and 15 always read 0, whatever is written to them.
- R4: Bit 5 of `rdata` is the written flag. It is 1 from the edge of the first write with `byte_en[0]` set, whatever the data. It then stays 1 until reset. Writing bit 5 neither sets nor clears it.
- R5: Writes with `byte_en[0]` clear never set the written flag.
- R6: `pin_oe` equals the written flag, so the shared address/write-enable pins are three-stated (0) from reset until the first low-byte write.
- R7: Select outputs equal stored bits, where 1 picks the second function: `sel_we_en` = bit 0 (1 = byte write enables, 0 = high address bits), `sel_oe` = bit 1 (1 = output enable, 0 = address-mux strobe), `sel_cas01_ack` = bit 2, `sel_cas23_ack` = bit 4, `sel_cs_ack` = bit 6, `sel_avec_ack` = bit 7 (each 1 = acknowledge function).
- R8: `rdata` shows the current stored value combinationally. During a write cycle it shows the old value until the edge. Cycles with `wr_en` low change nothing.
- R9: `hi_opts` equals `rdata[15:8]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| byte_en | input | 2 | Byte-lane enables for a write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Current register value including written flag |
| sel_we_en | output | 1 | Shared pins: 1 = byte write enables, 0 = high address bits |
| sel_oe | output | 1 | 1 = output enable, 0 = address-mux strobe |
| sel_cas01_ack | output | 1 | 1 = acknowledge strobes, 0 = column strobes 0/1 |
| sel_cas23_ack | output | 1 | 1 = acknowledge strobes, 0 = column strobes 2/3 |
| sel_cs_ack | output | 1 | 1 = level-7 acknowledge, 0 = chip select |
| sel_avec_ack | output | 1 | 1 = level-5 acknowledge, 0 = autovector input |
| hi_opts | output | 8 | High-byte option bits |
| pin_oe | output | 1 | Output enable for the shared address/write-enable pins |

## Verification
The bench builds the block with its default parameters: two 8-bit lanes, writable mask 16'h77D7 and the flag tracked on lane 0. With these values every reserved bit, the flag position and each lane enable can be hit by directed writes. A pseudo-random stream of enables and data then mixes high-only, low-only, dual-lane and idle cycles around the flag's first setting. A mid-run reset shows that the flag clears only through reset and that a write of only reserved low bits still sets it.

// File: rtl/pinsel_pkg.sv
// Package: bit positions of the pin-select word and the select bundle.
// Assumes a 16-bit word of two 8-bit lanes; positions are decoded by the
// pin multiplexers, so they are fixed here.
package pinsel_pkg;
    localparam int BIT_WE    = 0;
    localparam int BIT_OE    = 1;
    localparam int BIT_CAS01 = 2;
    localparam int BIT_CAS23 = 4;
    localparam int BIT_STAT  = 5;
    localparam int BIT_CS    = 6;
    localparam int BIT_AVEC  = 7;

    typedef struct packed {
        logic avec_ack;
        logic cs_ack;
        logic cas23_ack;
        logic cas01_ack;
        logic oe;
        logic we_en;
    } pin_sel_t;
endpackage

// File: rtl/pinsel_store.sv
// Module: byte-lane storage of the writable configuration bits.
// Assumes WR_MASK clears reserved and read-only positions; those stay 0.
module pinsel_store #(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 2,
    parameter int DATA_W    = LANE_W * NUM_LANES,
    parameter logic [DATA_W-1:0] WR_MASK = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_LANES-1:0] byte_en,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    q
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam logic [LANE_W-1:0] LANE_MASK = WR_MASK[g*LANE_W +: LANE_W];
        logic [LANE_W-1:0] lane_q;

        // Load masked write data into this lane when its enable is set.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (wr_en && byte_en[g])
                lane_q <= wdata[g*LANE_W +: LANE_W] & LANE_MASK;
        end

        assign q[g*LANE_W +: LANE_W] = lane_q;

        // R2
        lane_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && byte_en[g]) |=>
            (q[g*LANE_W +: LANE_W] == ($past(wdata[g*LANE_W +: LANE_W]) & LANE_MASK)));

        // R8
        lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && byte_en[g]) |=> $stable(q[g*LANE_W +: LANE_W]));
    end
endmodule

// File: rtl/pinsel_wtrack.sv
// Module: sticky flag recording the first write to the tracked lane.
// Assumes only reset clears it; the written data are not examined.
module pinsel_wtrack #(
    parameter int NUM_LANES  = 2,
    parameter int TRACK_LANE = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_LANES-1:0] byte_en,
    output logic                 written
);
    logic hit;
    assign hit = wr_en && byte_en[TRACK_LANE];

    // Set on a tracked-lane write, hold until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            written <= 1'b0;
        else if (hit)
            written <= 1'b1;
    end

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> written);

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        written |=> written);

    // R5
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!written && !hit) |=> !written);
endmodule

// File: rtl/pinsel_decode.sv
// Module: merges the flag into the read word and fans out the pin selects.
// Assumes default layout from pinsel_pkg; purely combinational.
module pinsel_decode
    import pinsel_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 2,
    parameter int DATA_W    = LANE_W * NUM_LANES
) (
    input  logic [DATA_W-1:0]        q,
    input  logic                     written,
    output logic [DATA_W-1:0]        rdata,
    output pin_sel_t                 sel,
    output logic [DATA_W-LANE_W-1:0] hi_opts,
    output logic                     pin_oe
);
    // Build the read word and the select bundle from stored bits.
    always_comb begin
        rdata           = q;
        rdata[BIT_STAT] = written;
        sel.we_en       = q[BIT_WE];
        sel.oe          = q[BIT_OE];
        sel.cas01_ack   = q[BIT_CAS01];
        sel.cas23_ack   = q[BIT_CAS23];
        sel.cs_ack      = q[BIT_CS];
        sel.avec_ack    = q[BIT_AVEC];
    end

    assign hi_opts = rdata[DATA_W-1:LANE_W];
    assign pin_oe  = written;
endmodule

// File: rtl/pin_select_reg.sv
// Module: top of the pin-function select register.
// Assumes a single-cycle write port with byte enables and a free-running read.
module pin_select_reg
    import pinsel_pkg::*;
#(
    parameter int LANE_W     = 8,
    parameter int NUM_LANES  = 2,
    parameter int TRACK_LANE = 0,
    parameter logic [LANE_W*NUM_LANES-1:0] WR_MASK = 16'h77D7,
    localparam int DATA_W    = LANE_W * NUM_LANES,
    localparam int HI_W      = DATA_W - LANE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_LANES-1:0] byte_en,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 sel_we_en,
    output logic                 sel_oe,
    output logic                 sel_cas01_ack,
    output logic                 sel_cas23_ack,
    output logic                 sel_cs_ack,
    output logic                 sel_avec_ack,
    output logic [HI_W-1:0]      hi_opts,
    output logic                 pin_oe
);
    logic [DATA_W-1:0] q;
    logic              written;
    pin_sel_t          sel;

    pinsel_store #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES), .DATA_W(DATA_W),
                   .WR_MASK(WR_MASK)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .byte_en(byte_en),
        .wdata(wdata), .q(q)
    );

    pinsel_wtrack #(.NUM_LANES(NUM_LANES), .TRACK_LANE(TRACK_LANE)) u_track (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .byte_en(byte_en),
        .written(written)
    );

    pinsel_decode #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) u_dec (
        .q(q), .written(written), .rdata(rdata), .sel(sel),
        .hi_opts(hi_opts), .pin_oe(pin_oe)
    );

    assign sel_we_en     = sel.we_en;
    assign sel_oe        = sel.oe;
    assign sel_cas01_ack = sel.cas01_ack;
    assign sel_cas23_ack = sel.cas23_ack;
    assign sel_cs_ack    = sel.cs_ack;
    assign sel_avec_ack  = sel.avec_ack;

    // R6
    pin_oe_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe) |-> $past(wr_en && byte_en[TRACK_LANE]));
endmodule

// File: tb/sim_pin_select_reg.sv
`timescale 1ns/1ps
module sim_pin_select_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  byte_en = 2'b00;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        sel_we_en, sel_oe, sel_cas01_ack, sel_cas23_ack, sel_cs_ack, sel_avec_ack;
    logic [7:0]  hi_opts;
    logic        pin_oe;

    int errors = 0;
    int checks = 0;
    int m_reg  = 0;   // model: stored writable bits
    int m_flag = 0;   // model: written flag
    bit done   = 0;
    int seed   = 32'h1234_5678;

    always #2.5 clk = ~clk;

    pin_select_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .byte_en(byte_en), .wdata(wdata),
        .rdata(rdata), .sel_we_en(sel_we_en), .sel_oe(sel_oe),
        .sel_cas01_ack(sel_cas01_ack), .sel_cas23_ack(sel_cas23_ack),
        .sel_cs_ack(sel_cs_ack), .sel_avec_ack(sel_avec_ack),
        .hi_opts(hi_opts), .pin_oe(pin_oe)
    );

    function automatic int exp_rd();
        return (m_reg & 32'h77D7) | (m_flag << 5);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        int e = exp_rd();
        check("R2/R8 rdata", int'(rdata), e);
        check("R3 reserved bits", int'(rdata) & 32'h8808, 0);
        check("R4/R5 flag", int'(rdata[5]), m_flag);
        check("R6 pin_oe", int'(pin_oe), m_flag);
        check("R7 sel_we_en", int'(sel_we_en), e & 1);
        check("R7 sel_oe", int'(sel_oe), (e >> 1) & 1);
        check("R7 sel_cas01_ack", int'(sel_cas01_ack), (e >> 2) & 1);
        check("R7 sel_cas23_ack", int'(sel_cas23_ack), (e >> 4) & 1);
        check("R7 sel_cs_ack", int'(sel_cs_ack), (e >> 6) & 1);
        check("R7 sel_avec_ack", int'(sel_avec_ack), (e >> 7) & 1);
        check("R9 hi_opts", int'(hi_opts), (e >> 8) & 32'hFF);
    endtask

    // One cycle: drive, check old value before edge (R8), update model, check after.
    task automatic step(input bit we, input bit [1:0] be, input bit [15:0] d);
        wr_en = we; byte_en = be; wdata = d;
        #1;
        check("R8 pre-edge rdata", int'(rdata), exp_rd());
        @(posedge clk);
        if (we && be[0]) begin
            m_reg = (m_reg & 32'hFF00) | (int'(d) & 32'h00D7);
            m_flag = 1;
        end
        if (we && be[1]) m_reg = (m_reg & 32'h00FF) | (int'(d) & 32'h7700);
        #1;
        check_all();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; byte_en = 2'b00; wdata = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_reg = 0; m_flag = 0;
        #1;
        // R1 reset state
        check_all();
        check("R1 rdata zero", int'(rdata), 0);
    endtask

    initial begin
        #(5ns * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        step(1, 2'b10, 16'hFFFF);   // R5 high-only write leaves flag clear
        step(0, 2'b11, 16'hFFFF);   // R8 idle cycle changes nothing
        step(1, 2'b00, 16'hFFFF);   // R2 no lanes enabled
        step(1, 2'b01, 16'h0020);   // R4 flag set; bit-5 data ignored
        step(1, 2'b01, 16'h0000);   // R4 flag stays set
        step(1, 2'b01, 16'hFFFF);   // R3 reserved bit 3 reads 0
        step(1, 2'b11, 16'hA5C3);   // R2 both lanes
        step(1, 2'b10, 16'h0000);   // R2 high lane only
        for (int i = 0; i < 60; i++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            step(seed[0], seed[2:1], seed[31:16]);
        end
        do_reset();                 // R4 flag cleared only by reset
        step(1, 2'b10, 16'h0020);   // R5 still clear after high-only
        step(1, 2'b01, 16'h0008);   // R4 reserved-only low write still sets flag
        step(1, 2'b01, 16'h00FF);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule